// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This controller decides what happens when software asks for a start condition on an I2C bus. It sits between a bus-state monitor, which reports detected start and stop conditions, arbitration loss and slave address matches, and a master engine, which drives the start sequence when the controller pulses its start-generate output. If the bus is free, the request turns into a start straight away. If the bus is held by other traffic and the reservation feature is enabled, the request is stored as a single pending reservation. The start then fires on its own when the next stop condition appears.

The controller also qualifies address-register writes. A write counts only while the device is master. Anything written while a reservation waits for the stop is discarded. A pending reservation is dropped if arbitration is lost or if another master addresses this device as a slave first.

States: FREE (bus released, device idle), BUSY (other traffic on the bus, device neither master nor slave), SLAVE (device addressed as a slave), PEND (reservation held), MASTER (start issued). Transitions:
- FREE to MASTER on a request.
- FREE to BUSY or PEND on a foreign start.
- BUSY to FREE on a stop.
- BUSY to SLAVE on a slave hit.
- BUSY to PEND on an enabled request.
- SLAVE to FREE on a stop.
- SLAVE to BUSY on a software release.
- PEND to MASTER on a stop.
- PEND to BUSY on an arbitration loss.
- PEND to SLAVE on a slave hit.
- MASTER to FREE on a stop.
- MASTER to BUSY or SLAVE on an arbitration loss.

Top module: `i2c_start_rsv_ctrl`

## Requirements
- R1: After reset, start_gen_o, mst_o and rsv_pend_o are 0, and the bus is treated as free.
- R2: A start_req_i pulse while the bus is free gives start_gen_o = 1 for exactly one cycle and mst_o = 1, both visible in the cycle after the request, with rsv_pend_o = 0.
- R3: After start_det_i with no later stop_det_i, a start_req_i with rsv_dis_i = 0 sets rsv_pend_o in the next cycle, without start_gen_o and without mst_o.
- R4: The reservation feature is enabled only by the encoding rsv_dis_i = 0. With rsv_dis_i = 1, a request made while the bus is busy is dropped: no start, no pending flag, mst_o stays 0.
- R5: While rsv_pend_o = 1, a stop_det_i pulse gives start_gen_o = 1 and mst_o = 1 in the next cycle, and rsv_pend_o clears.
- R6: After an arbitration loss leaves the device idle on a busy bus, an enabled start request becomes a reservation.
- R7: While the device is addressed as a slave (slave_hit_i), start requests are ignored. After slv_release_i, an enabled request becomes a reservation.
- R8: wr_valid_o equals addr_wr_i while mst_o = 1 and is 0 otherwise. This includes writes made during a reservation and in the cycle of the stop that ends it.
- R9: arb_lost_i or slave_hit_i during a reservation clears rsv_pend_o without start_gen_o or mst_o. If either arrives in the same cycle as stop_det_i, it wins over the stop.
- R10: While master, stop_det_i or arb_lost_i clears mst_o in the next cycle.
- R11: A second start_req_i while a reservation is pending is ignored: only one start_gen_o pulse follows the stop.
- R12: start_req_i and start_det_i in the same cycle on a free bus are treated as a request on a busy bus: with rsv_dis_i = 0 it becomes a reservation and no start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req_i | input | 1 | Software start request strobe |
| rsv_dis_i | input | 1 | 0 enables reservation, 1 disables it |
| start_det_i | input | 1 | Start condition seen on the bus |
| stop_det_i | input | 1 | Stop condition seen on the bus |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| slave_hit_i | input | 1 | Device addressed as slave |
| slv_release_i | input | 1 | Software releases the bus from slave mode without ACK |
| addr_wr_i | input | 1 | Address/data register write strobe |
| start_gen_o | output | 1 | One-cycle command to the master engine to generate a start |
| mst_o | output | 1 | Master status |
| rsv_pend_o | output | 1 | Reservation pending |
| wr_valid_o | output | 1 | Qualifies addr_wr_i as a write to transmit |

## Verification
The main function is exercised with requests on a free bus, on a bus busy with foreign traffic, after arbitration loss and after a slave release. Comparing these cases separates an immediate start from a stored reservation and shows which idle conditions allow one. The reservation-enable setting is flipped on the busy path to tell a dropped request from a held one. Colliding events are also driven in the same cycle: a request with a foreign start, a stop with an arbitration loss or slave hit, and a write with the stop that releases a reservation. These show that the priorities hold and that stale writes never count.

// File: rtl/i2c_rsv_pkg.sv
package i2c_rsv_pkg;

    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_BUSY   = 3'd1,
        ST_SLAVE  = 3'd2,
        ST_PEND   = 3'd3,
        ST_MASTER = 3'd4
    } rsv_state_t;

    typedef struct packed {
        logic start_req;
        logic rsv_en;
        logic start_det;
        logic stop_det;
        logic arb_lost;
        logic slave_hit;
        logic slv_release;
    } rsv_evt_t;

endpackage

// File: rtl/i2c_rsv_next.sv
module i2c_rsv_next
    import i2c_rsv_pkg::*;
(
    input  rsv_state_t cur_i,
    input  rsv_evt_t   evt_i,
    output rsv_state_t nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            ST_FREE: begin
                if (evt_i.start_det) begin
                    nxt_o = (evt_i.start_req && evt_i.rsv_en) ? ST_PEND : ST_BUSY;
                end else if (evt_i.start_req) begin
                    nxt_o = ST_MASTER;
                end
            end
            ST_BUSY: begin
                if (evt_i.stop_det) begin
                    nxt_o = ST_FREE;
                end else if (evt_i.slave_hit) begin
                    nxt_o = ST_SLAVE;
                end else if (evt_i.start_req && evt_i.rsv_en) begin
                    nxt_o = ST_PEND;
                end
            end
            ST_SLAVE: begin
                if (evt_i.stop_det) begin
                    nxt_o = ST_FREE;
                end else if (evt_i.slv_release) begin
                    nxt_o = ST_BUSY;
                end
            end
            ST_PEND: begin
                if (evt_i.slave_hit) begin
                    nxt_o = ST_SLAVE;
                end else if (evt_i.arb_lost) begin
                    nxt_o = ST_BUSY;
                end else if (evt_i.stop_det) begin
                    nxt_o = ST_MASTER;
                end
            end
            ST_MASTER: begin
                if (evt_i.stop_det) begin
                    nxt_o = ST_FREE;
                end else if (evt_i.arb_lost) begin
                    nxt_o = evt_i.slave_hit ? ST_SLAVE : ST_BUSY;
                end
            end
            default: nxt_o = ST_FREE;
        endcase
    end

endmodule

// File: rtl/i2c_rsv_out.sv
module i2c_rsv_out
    import i2c_rsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rsv_state_t cur_i,
    input  rsv_state_t nxt_i,
    input  logic       addr_wr_i,
    input  logic       stop_det_i,
    input  logic       arb_lost_i,
    input  logic       slave_hit_i,
    input  logic       start_req_i,
    input  logic       rsv_en_i,
    output logic       start_gen_o,
    output logic       mst_o,
    output logic       rsv_pend_o,
    output logic       wr_valid_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_gen_o <= 1'b0;
            mst_o       <= 1'b0;
            rsv_pend_o  <= 1'b0;
        end else begin
            start_gen_o <= (nxt_i == ST_MASTER) && (cur_i != ST_MASTER);
            mst_o       <= (nxt_i == ST_MASTER);
            rsv_pend_o  <= (nxt_i == ST_PEND);
        end
    end

    always_comb begin
        wr_valid_o = addr_wr_i && mst_o;
    end

    AST_GEN_WITH_MST: assert property (@(posedge clk) disable iff (!rst_n)
        start_gen_o |-> mst_o); // R2
    AST_GEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_gen_o |=> !start_gen_o); // R2
    AST_PEND_EXCL_MST: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsv_pend_o && mst_o)); // R3
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsv_pend_o) |-> $past(start_req_i && rsv_en_i)); // R4
    AST_STOP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_pend_o && stop_det_i && !arb_lost_i && !slave_hit_i) |=> (start_gen_o && !rsv_pend_o)); // R5
    AST_WR_ONLY_MST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> mst_o); // R8
    AST_CANCEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_pend_o && (arb_lost_i || slave_hit_i)) |=> (!rsv_pend_o && !mst_o && !start_gen_o)); // R9
    AST_MST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_o && (stop_det_i || arb_lost_i)) |=> !mst_o); // R10

endmodule

// File: rtl/i2c_start_rsv_ctrl.sv
module i2c_start_rsv_ctrl
    import i2c_rsv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    input  logic rsv_dis_i,
    input  logic start_det_i,
    input  logic stop_det_i,
    input  logic arb_lost_i,
    input  logic slave_hit_i,
    input  logic slv_release_i,
    input  logic addr_wr_i,
    output logic start_gen_o,
    output logic mst_o,
    output logic rsv_pend_o,
    output logic wr_valid_o
);

    rsv_state_t state_q;
    rsv_state_t state_d;
    rsv_evt_t   evt;

    always_comb begin
        evt.start_req   = start_req_i;
        evt.rsv_en      = !rsv_dis_i;
        evt.start_det   = start_det_i;
        evt.stop_det    = stop_det_i;
        evt.arb_lost    = arb_lost_i;
        evt.slave_hit   = slave_hit_i;
        evt.slv_release = slv_release_i;
    end

    i2c_rsv_next u_next (
        .cur_i (state_q),
        .evt_i (evt),
        .nxt_o (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    i2c_rsv_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_i       (state_q),
        .nxt_i       (state_d),
        .addr_wr_i   (addr_wr_i),
        .stop_det_i  (stop_det_i),
        .arb_lost_i  (arb_lost_i),
        .slave_hit_i (slave_hit_i),
        .start_req_i (start_req_i),
        .rsv_en_i    (!rsv_dis_i),
        .start_gen_o (start_gen_o),
        .mst_o       (mst_o),
        .rsv_pend_o  (rsv_pend_o),
        .wr_valid_o  (wr_valid_o)
    );

    AST_SECOND_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && start_req_i && !stop_det_i && !arb_lost_i && !slave_hit_i)
        |=> (state_q == ST_PEND)); // R11
    AST_SLAVE_NO_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLAVE && start_req_i) |=> !rsv_pend_o); // R7

endmodule

// File: tb/tb_i2c_start_rsv_ctrl.sv
module tb_i2c_start_rsv_ctrl;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 0, rsv_dis = 0, start_det = 0, stop_det = 0;
    logic arb_lost = 0, slave_hit = 0, slv_release = 0, addr_wr = 0;
    logic start_gen, mst, rsv_pend, wr_valid;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_start_rsv_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req_i   (start_req),
        .rsv_dis_i     (rsv_dis),
        .start_det_i   (start_det),
        .stop_det_i    (stop_det),
        .arb_lost_i    (arb_lost),
        .slave_hit_i   (slave_hit),
        .slv_release_i (slv_release),
        .addr_wr_i     (addr_wr),
        .start_gen_o   (start_gen),
        .mst_o         (mst),
        .rsv_pend_o    (rsv_pend),
        .wr_valid_o    (wr_valid)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic g, input logic m, input logic p);
        chk(req, "start_gen", start_gen, g);
        chk(req, "mst", mst, m);
        chk(req, "rsv_pend", rsv_pend, p);
    endtask

    // Advance one clock edge, sample 1 time unit later, then clear strobes.
    task automatic cyc();
        @(posedge clk);
        #1;
        start_req = 0; start_det = 0; stop_det = 0; arb_lost = 0;
        slave_hit = 0; slv_release = 0; addr_wr = 0;
    endtask

    task automatic t_reset();
        chk_out("R1", 1'b0, 1'b0, 1'b0);
        addr_wr = 1; #1;
        chk("R8", "wr_valid idle", wr_valid, 1'b0);
        cyc();
    endtask

    task automatic t_free_start();
        start_req = 1; cyc();
        chk_out("R2", 1'b1, 1'b1, 1'b0);
        cyc();
        chk_out("R2", 1'b0, 1'b1, 1'b0);
        addr_wr = 1; #1;
        chk("R8", "wr_valid master", wr_valid, 1'b1);
        cyc();
        stop_det = 1; cyc();
        chk("R10", "mst after stop", mst, 1'b0);
    endtask

    task automatic t_busy_rsv();
        start_det = 1; cyc();
        chk_out("R3", 1'b0, 1'b0, 1'b0);
        start_req = 1; cyc();
        chk_out("R3", 1'b0, 1'b0, 1'b1);
        addr_wr = 1; #1;
        chk("R8", "wr_valid pending", wr_valid, 1'b0);
        cyc();
        start_req = 1; cyc();
        chk_out("R11", 1'b0, 1'b0, 1'b1);
        stop_det = 1; addr_wr = 1; #1;
        chk("R8", "wr_valid at stop", wr_valid, 1'b0);
        cyc();
        chk_out("R5", 1'b1, 1'b1, 1'b0);
        cyc();
        chk_out("R11", 1'b0, 1'b1, 1'b0);
        addr_wr = 1; #1;
        chk("R8", "wr_valid after auto start", wr_valid, 1'b1);
        cyc();
        arb_lost = 1; cyc();
        chk_out("R10", 1'b0, 1'b0, 1'b0);
        stop_det = 1; cyc();
    endtask

    task automatic t_disabled();
        start_det = 1; cyc();
        rsv_dis = 1; start_req = 1; cyc();
        chk_out("R4", 1'b0, 1'b0, 1'b0);
        cyc();
        chk_out("R4", 1'b0, 1'b0, 1'b0);
        stop_det = 1; cyc();
        start_req = 1; cyc();
        chk_out("R4", 1'b1, 1'b1, 1'b0);
        rsv_dis = 0;
        stop_det = 1; cyc();
    endtask

    task automatic t_arb();
        start_req = 1; cyc();
        chk_out("R2", 1'b1, 1'b1, 1'b0);
        arb_lost = 1; cyc();
        chk_out("R10", 1'b0, 1'b0, 1'b0);
        start_req = 1; cyc();
        chk_out("R6", 1'b0, 1'b0, 1'b1);
        arb_lost = 1; cyc();
        chk_out("R9", 1'b0, 1'b0, 1'b0);
        stop_det = 1; cyc();
        chk_out("R9", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_slave();
        start_det = 1; cyc();
        slave_hit = 1; cyc();
        start_req = 1; cyc();
        chk_out("R7", 1'b0, 1'b0, 1'b0);
        slv_release = 1; cyc();
        start_req = 1; cyc();
        chk_out("R7", 1'b0, 1'b0, 1'b1);
        slave_hit = 1; stop_det = 1; cyc();
        chk_out("R9", 1'b0, 1'b0, 1'b0);
        stop_det = 1; cyc();
    endtask

    task automatic t_race();
        start_req = 1; start_det = 1; cyc();
        chk_out("R12", 1'b0, 1'b0, 1'b1);
        stop_det = 1; cyc();
        chk_out("R12", 1'b1, 1'b1, 1'b0);
        stop_det = 1; cyc();
        chk_out("R10", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        t_reset();
        rst_n = 1;
        cyc();
        chk_out("R1", 1'b0, 1'b0, 1'b0);
        t_free_start();
        t_busy_rsv();
        t_disabled();
        t_arb();
        t_slave();
        t_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule